// File: doc/BRIEF.md
# Multi-Enable Interrupt Pending Aggregator

This block gathers a parameterised set of level-sensitive interrupt sources and presents a single interrupt request, plus a vector code, to a processor. A source does not have one enable bit. It has an enable counter that rises and falls with per-source increment and decrement strobes. The source may interrupt only while that counter equals a fixed per-source requirement. The requirement equals the number of independent enabling agents (mask bits, priority fields, group entries) that refer to the source. A source whose requirement is zero is enabled as soon as its level is high.

Every cycle the block samples the source levels and updates the enable counters. It keeps a running count of pending sources. The request line is high whenever that count is non-zero. Alongside the request it offers the vector of the lowest-numbered pending source, unless the processor's 4-bit mask is at its all-ones value, which blocks every vector. Source 0 is reserved and never pends.

Top module: `intc_pend_agg`

## Requirements
- R1: A source is pending exactly when its asserted flag is set and its enable count equals its required count.
- R2: Required counts are given by parameter `EN_REQ`, 2 bits per source, with source i at bits [2i+1:2i]. The default gives sources 0..7 the counts 0,1,2,0,1,2,0,1.
- R3: A source's asserted flag follows its level input, registered on the clock edge. A high level on a non-asserted source asserts it, and a low level on an asserted source releases it.
- R4: An increment strobe raises the enable count by one and a decrement strobe lowers it by one. A strobe that would take the count above its requirement or below zero is ignored. Increment and decrement in the same cycle leave the count unchanged.
- R5: A global counter tracks the number of pending sources. `irq_req` is high exactly when that counter is non-zero. It reflects input changes two clock edges after they are sampled.
- R6: When `cpu_mask` equals 4'hF, `vec_valid` is low and `vec_code` is zero. `irq_req` is unaffected.
- R7: Otherwise `vec_valid` is high when any source is pending, and `vec_code` is the vector of the lowest-indexed pending source. Source i has the vector `VEC_BASE + i*VEC_STEP`, which is 0x400 + 0x20*i by default. With no pending source, `vec_code` is zero.
- R8: Source 0 is reserved and never becomes pending, whatever its level and strobes.
- R9: A synchronous active-low reset clears all asserted flags, all enable counts and the global counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_level | input | NUM_SRC | Per-source interrupt level |
| en_inc | input | NUM_SRC | Per-source enable increment strobe |
| en_dec | input | NUM_SRC | Per-source enable decrement strobe |
| cpu_mask | input | 4 | Processor interrupt mask; 4'hF blocks vectors |
| irq_req | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector output is meaningful |
| vec_code | output | VEC_W | Vector of the selected pending source |

## Verification
The hardest case to reach is an enable count pressed against one of its limits while the source's level and its neighbours keep changing. The cases are an increment at a count already at its requirement, a decrement at zero, and both strobes in one cycle. A fault there only shows up later, as a source that pends when it should not or fails to pend. The stimulus table therefore drives strobes at the limits while the level stays asserted. It then makes the effect visible through the selected vector, by releasing the lower-numbered competitor. Directed steps after reset drive a decrement from zero followed by a single increment, which exposes any wrap-around.

// File: rtl/intc_agg_pkg.sv
// Shared definitions for the pending aggregator.
// Assumes: enable strobes are single-cycle qualifiers sampled on clk.
package intc_agg_pkg;
    typedef enum logic [1:0] {
        EN_HOLD = 2'd0,
        EN_UP   = 2'd1,
        EN_DOWN = 2'd2
    } en_step_t;
endpackage

// File: rtl/intc_src_slot.sv
// One interrupt source: asserted flag and enable counter.
// Assumes: REQ fits in CNT_W bits; RESERVED slots never pend.
module intc_src_slot
    import intc_agg_pkg::*;
#(
    parameter int CNT_W    = 2,
    parameter int REQ      = 1,
    parameter bit RESERVED = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic inc,
    input  logic dec,
    output logic pending
);
    localparam logic [CNT_W-1:0] REQ_V = CNT_W'(REQ);

    logic             asserted_q;
    logic [CNT_W-1:0] cnt_q;
    en_step_t         step;

    // Decode strobes into one step, dropping moves past the limits.
    always_comb begin
        step = EN_HOLD;
        if (inc && !dec && cnt_q != REQ_V)
            step = EN_UP;
        else if (dec && !inc && cnt_q != '0)
            step = EN_DOWN;
    end

    // Register the level and apply the enable step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asserted_q <= 1'b0;
            cnt_q      <= '0;
        end else begin
            asserted_q <= level;
            case (step)
                EN_UP:   cnt_q <= cnt_q + 1'b1;
                EN_DOWN: cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Pending when asserted and every enable contribution is present.
    always_comb pending = !RESERVED && asserted_q && (cnt_q == REQ_V);

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= REQ_V); // R4
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == REQ_V && inc && !dec) |=> cnt_q == REQ_V); // R4
    AST_FLOOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && dec && !inc) |=> cnt_q == '0); // R4
    AST_PEND_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> $past(level)); // R3
endmodule

// File: rtl/intc_pend_count.sv
// Global pending counter built from per-source pending transitions.
// Assumes: pend_in comes from registered state and is stable between edges.
module intc_pend_count #(
    parameter int NUM_SRC = 8,
    parameter int GCNT_W  = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_in,
    output logic               irq_req
);
    logic [NUM_SRC-1:0] pend_q;
    logic [GCNT_W-1:0]  count_q;
    logic [GCNT_W-1:0]  rises, falls;

    // Count sources that became pending or stopped pending.
    always_comb begin
        rises = '0;
        falls = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend_in[i] && !pend_q[i]) rises = rises + 1'b1;
            if (!pend_in[i] && pend_q[i]) falls = falls + 1'b1;
        end
    end

    // Keep the previous pending picture and the running count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            count_q <= '0;
        end else begin
            pend_q  <= pend_in;
            count_q <= count_q + rises - falls;
        end
    end

    // Request follows the count being non-zero.
    always_comb irq_req = (count_q != '0);

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= GCNT_W'(NUM_SRC)); // R5
    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == ($past(pend_in) != '0)); // R5
endmodule

// File: rtl/intc_vec_pick.sv
// Chooses the lowest-indexed pending source and forms its vector.
// Assumes: mask 4'hF blocks all vectors; vector i = BASE + i*STEP.
module intc_vec_pick #(
    parameter int NUM_SRC  = 8,
    parameter int VEC_W    = 12,
    parameter int VEC_BASE = 'h400,
    parameter int VEC_STEP = 'h20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_in,
    input  logic [3:0]         cpu_mask,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec_code
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [IDX_W-1:0] sel;
    logic             any;

    // Scan from the top so the lowest pending index wins.
    always_comb begin
        sel = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--)
            if (pend_in[i]) sel = IDX_W'(i);
        any = |pend_in;
    end

    // Gate by the mask and map the index to its vector.
    always_comb begin
        vec_valid = any && (cpu_mask != 4'hF);
        vec_code  = vec_valid ? VEC_W'(VEC_BASE + int'(sel) * VEC_STEP) : '0;
    end

    AST_MASK_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_mask == 4'hF) |-> !vec_valid); // R6
    AST_VALID_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> pend_in[sel]); // R7
endmodule

// File: rtl/intc_pend_agg.sv
// Top: per-source slots, global pending counter and vector selection.
// Assumes: EN_REQ packs CNT_W bits per source; source 0 is reserved.
module intc_pend_agg #(
    parameter int                   NUM_SRC  = 8,
    parameter int                   CNT_W    = 2,
    parameter int                   VEC_W    = 12,
    parameter int                   VEC_BASE = 'h400,
    parameter int                   VEC_STEP = 'h20,
    parameter logic [NUM_SRC*CNT_W-1:0] EN_REQ = 16'h4924
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_level,
    input  logic [NUM_SRC-1:0] en_inc,
    input  logic [NUM_SRC-1:0] en_dec,
    input  logic [3:0]         cpu_mask,
    output logic               irq_req,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec_code
);
    logic [NUM_SRC-1:0] pend;

    // One slot per source; slot 0 is built reserved.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
        intc_src_slot #(
            .CNT_W   (CNT_W),
            .REQ     (int'(EN_REQ[g*CNT_W +: CNT_W])),
            .RESERVED(g == 0)
        ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .level  (src_level[g]),
            .inc    (en_inc[g]),
            .dec    (en_dec[g]),
            .pending(pend[g])
        );
    end

    intc_pend_count #(.NUM_SRC(NUM_SRC)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_in(pend),
        .irq_req(irq_req)
    );

    intc_vec_pick #(
        .NUM_SRC (NUM_SRC),
        .VEC_W   (VEC_W),
        .VEC_BASE(VEC_BASE),
        .VEC_STEP(VEC_STEP)
    ) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_in  (pend),
        .cpu_mask (cpu_mask),
        .vec_valid(vec_valid),
        .vec_code (vec_code)
    );

    AST_RSV_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (src_level == 8'h01 && $past(src_level) == 8'h01 && cpu_mask != 4'hF)
            |-> (!vec_valid || vec_code != VEC_W'(VEC_BASE))); // R8
endmodule

// File: tb/intc_pend_agg_test.sv
module intc_pend_agg_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src_level = '0, en_inc = '0, en_dec = '0;
    logic [3:0] cpu_mask = '0;
    logic       irq_req, vec_valid;
    logic [11:0] vec_code;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    intc_pend_agg uut (
        .clk(clk), .rst_n(rst_n), .src_level(src_level), .en_inc(en_inc),
        .en_dec(en_dec), .cpu_mask(cpu_mask), .irq_req(irq_req),
        .vec_valid(vec_valid), .vec_code(vec_code)
    );

    typedef struct packed {
        logic [7:0]  lvl;
        logic [7:0]  inc;
        logic [7:0]  dec;
        logic [3:0]  mask;
        logic        x_irq;
        logic        x_val;
        logic [11:0] x_vec;
    } row_t;

    // Required counts: s0..s7 = 0,1,2,0,1,2,0,1; vector i = 0x400+0x20*i.
    localparam row_t TABLE [10] = '{
        '{8'h08, 8'h00, 8'h00, 4'h0, 1'b1, 1'b1, 12'h460}, // R1 R7 req-0 source
        '{8'h0A, 8'h02, 8'h00, 4'h0, 1'b1, 1'b1, 12'h420}, // R7 lower index wins
        '{8'h0A, 8'h00, 8'h00, 4'hF, 1'b1, 1'b0, 12'h000}, // R6 mask blocks
        '{8'h0A, 8'h00, 8'h02, 4'h0, 1'b1, 1'b1, 12'h460}, // R4 dec drops s1
        '{8'h02, 8'h00, 8'h00, 4'h0, 1'b0, 1'b0, 12'h000}, // R3 R5 none pending
        '{8'h03, 8'h03, 8'h00, 4'h0, 1'b1, 1'b1, 12'h420}, // R8 s0 never pends
        '{8'h22, 8'h22, 8'h00, 4'h0, 1'b1, 1'b1, 12'h420}, // R4 inc at limit ignored
        '{8'h20, 8'h20, 8'h00, 4'h0, 1'b1, 1'b1, 12'h4A0}, // R2 s5 needs two
        '{8'h20, 8'h20, 8'h20, 4'h0, 1'b1, 1'b1, 12'h4A0}, // R4 both strobes hold
        '{8'h01, 8'h00, 8'h00, 4'h0, 1'b0, 1'b0, 12'h000}  // R8 only reserved high
    };

    task automatic check(string req, logic [11:0] act, logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One stimulus cycle of strobes, then settle past both register stages.
    task automatic apply(logic [7:0] lvl, logic [7:0] inc, logic [7:0] dec, logic [3:0] m);
        src_level = lvl; en_inc = inc; en_dec = dec; cpu_mask = m;
        @(posedge clk); #1;
        en_inc = '0; en_dec = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset irq", {11'b0, irq_req}, 12'h0);
        check("R9 reset valid", {11'b0, vec_valid}, 12'h0);
        rst_n = 1'b1;

        for (int i = 0; i < 10; i++) begin
            apply(TABLE[i].lvl, TABLE[i].inc, TABLE[i].dec, TABLE[i].mask);
            check($sformatf("R5 row%0d irq", i), {11'b0, irq_req}, {11'b0, TABLE[i].x_irq});
            check($sformatf("R7 row%0d valid", i), {11'b0, vec_valid}, {11'b0, TABLE[i].x_val});
            check($sformatf("R7 row%0d vec", i), vec_code, TABLE[i].x_vec);
        end

        // R9: reset while s3 pending and s5 fully enabled.
        apply(8'h28, 8'h00, 8'h00, 4'h0);
        check("R9 pre-reset vec", vec_code, 12'h460);
        src_level = 8'h00;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R9 in reset irq", {11'b0, irq_req}, 12'h0);
        rst_n = 1'b1;
        apply(8'h20, 8'h00, 8'h00, 4'h0);
        check("R9 count cleared", {11'b0, irq_req}, 12'h0);

        // R4: decrement at zero must not wrap; one increment then enables s1.
        apply(8'h02, 8'h00, 8'h02, 4'h0);
        check("R4 dec at zero", {11'b0, irq_req}, 12'h0);
        apply(8'h02, 8'h02, 8'h00, 4'h0);
        check("R4 inc after floor", vec_code, 12'h420);

        // R5: latency, irq rises two edges after level sampled.
        apply(8'h00, 8'h00, 8'h00, 4'h0);
        src_level = 8'h40;
        @(posedge clk); @(negedge clk);
        check("R5 irq not yet", {11'b0, irq_req}, 12'h0);
        @(posedge clk); @(negedge clk);
        check("R5 irq after two", {11'b0, irq_req}, 12'h1);
        check("R7 s6 vector", vec_code, 12'h4C0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule